// File: doc/BRIEF.md
# Serial GPIO Line Interrupt Sensing

This block watches a bank of GPIO lines that a serial shifter samples elsewhere and delivers as one parallel word with an update strobe. On every strobe it compares the new word against the last captured word and tests each line against its own sense mode. The mode is one of: rising edge, falling edge, both edges, level high, level low, or none. When a line's condition fires, its status bit is latched.

Software reaches the block through a plain register port: byte address, write data, write strobe and combinational read data. Through it software sets the enable mask, clears status bits by writing ones, programs the three type planes and reads back the live sampled word. Lines come in ports of eight. A port occupies eight adjacent bits of a register, and four ports share one 32-bit word. The block raises one combined interrupt. It also gives a per-port pending flag so that a handler can find the active port without scanning every line.

Top module: `sgpio_irq_sense`

## Requirements
- R1: After reset the enable mask is 0, status is 0, type plane 0 and type plane 1 read all ones, type plane 2 reads 0 (level-high sensing on every line), and the live word reads 0.
- R2: Registers sit at byte addresses 0x00 enable, 0x04 status, 0x08 type plane 0, 0x0C type plane 1, 0x10 type plane 2 and 0x14 live word (read only). A write to any register except status and live stores the write data. Reads return the addressed register with no delay.
- R3: A write to status clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R4: The code {plane2,plane1,plane0} = 001 senses a rising edge: the line was 0 in the previous sample and is 1 in the new one.
- R5: Any code with plane2 = 1, except 110, senses a falling edge.
- R6: The code 010 senses either edge.
- R7: The code 011 senses level high: the status bit is set on every strobe whose sample is 1, so it is set again after a clear while the line stays high.
- R8: The code 110 senses level low: the status bit is set on every strobe whose sample is 0.
- R9: The code 000 never sets the status bit.
- R10: A status bit is set whether or not its line is enabled. The interrupt output is the OR over all lines of status AND enable. Pending bit p is the same OR taken only over bits 8p to 8p+7.
- R11: If a status clear and a new event hit the same bit in the same cycle, the bit stays set.
- R12: Lines are evaluated only in a cycle with the update strobe. The live word takes the strobed sample, and edges compare against it. Without a strobe, status changes only through clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 32 | Read data for addr |
| in_data | input | 32 | Sampled line word from the serial shifter |
| in_valid | input | 1 | Update strobe for in_data |
| irq | output | 1 | Combined interrupt |
| port_pend | output | 4 | Per-port pending summary |

## Verification
The assertions assume that in_valid and wr_en are single-cycle qualifiers, and that addr and wdata have meaning only while wr_en is high. They also assume that the sample register starts from zero, so a line that first arrives high counts as a rising edge. The stimulus drives every input at the falling clock edge and holds each strobe for exactly one cycle. It drives a strobe together with a status write only in the test that covers that collision. Each stimulus word is chosen so that one line per sense code meets its condition while the others stay quiet.

// File: rtl/sgpio_irq_sense.sv
module sgpio_irq_sense #(
  parameter int LINES  = 32,
  parameter int PORT_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  input  logic              wr_en,
  output logic [LINES-1:0]  rdata,
  input  logic [LINES-1:0]  in_data,
  input  logic              in_valid,
  output logic              irq,
  output logic [LINES/PORT_W-1:0] port_pend
);
  localparam int NPORTS = LINES / PORT_W;
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_T0   = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_T1   = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_T2   = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(5'h14);

  logic [LINES-1:0] en_q, sts_q, t0_q, t1_q, t2_q, live_q;
  logic [LINES-1:0] rise_e, fall_e, hit, clr, masked;
  logic [LINES-1:0] m_rise, m_fall, m_both, m_hi, m_lo;

  assign m_rise = t0_q & ~t1_q & ~t2_q;
  assign m_both = ~t0_q & t1_q & ~t2_q;
  assign m_hi   = t0_q & t1_q & ~t2_q;
  assign m_lo   = ~t0_q & t1_q & t2_q;
  assign m_fall = t2_q & ~(t1_q & ~t0_q);

  assign rise_e = in_data & ~live_q;
  assign fall_e = ~in_data & live_q;

  assign hit = in_valid ? ((m_rise & rise_e) | (m_fall & fall_e) |
                           (m_both & (rise_e | fall_e)) |
                           (m_hi & in_data) | (m_lo & ~in_data))
                        : '0;

  assign clr = (wr_en && addr == A_STS) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sts_q  <= '0;
      t0_q   <= '1;
      t1_q   <= '1;
      t2_q   <= '0;
      live_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | hit;
      if (in_valid) live_q <= in_data;
      if (wr_en) begin
        case (addr)
          A_EN:    en_q <= wdata;
          A_T0:    t0_q <= wdata;
          A_T1:    t1_q <= wdata;
          A_T2:    t2_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_EN:    rdata = en_q;
      A_STS:   rdata = sts_q;
      A_T0:    rdata = t0_q;
      A_T1:    rdata = t1_q;
      A_T2:    rdata = t2_q;
      A_LIVE:  rdata = live_q;
      default: rdata = '0;
    endcase
  end

  assign masked = sts_q & en_q;
  assign irq    = |masked;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign port_pend[p] = |masked[p*PORT_W +: PORT_W];
  end

  // R3
  sts_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sts_q) & ~sts_q) & ~(($past(wr_en) && $past(addr) == A_STS) ? $past(wdata) : '0)) == '0));

  // R12
  sts_quiet_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !wr_en) |=> $stable(sts_q));

  // R12
  live_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> live_q == $past(in_data));

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0 && sts_q != '0));

  // R10
  pend_matches_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (port_pend != '0));

  // R11
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((sts_q & $past(hit)) == $past(hit)));
endmodule

// File: tb/tb_sgpio_irq_sense.sv
module tb_sgpio_irq_sense;
  logic clk = 0, rst_n = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, in_data = 0, rdata;
  logic wr_en = 0, in_valid = 0, irq;
  logic [3:0] port_pend;
  int checks = 0, errors = 0;

  sgpio_irq_sense dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rdata(rdata), .in_data(in_data), .in_valid(in_valid),
    .irq(irq), .port_pend(port_pend));

  always #5 clk = ~clk;

  logic [31:0] m_en, m_sts, m_t0, m_t1, m_t2, m_live;

  function automatic bit line_event(bit [2:0] code, bit was, bit now);
    case (code)
      3'b001: return !was && now;
      3'b010: return was != now;
      3'b011: return now;
      3'b110: return !now;
      3'b100, 3'b101, 3'b111: return was && !now;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return m_en;
      5'h04: return m_sts;
      5'h08: return m_t0;
      5'h0C: return m_t1;
      5'h10: return m_t2;
      5'h14: return m_live;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sts = 0; m_t0 = '1; m_t1 = '1; m_t2 = 0; m_live = 0;
    end else begin
      logic [31:0] nxt;
      nxt = m_sts;
      if (wr_en && addr == 5'h04) nxt = nxt & ~wdata;
      if (in_valid)
        for (int i = 0; i < 32; i++)
          if (line_event({m_t2[i], m_t1[i], m_t0[i]}, m_live[i], in_data[i])) nxt[i] = 1;
      if (in_valid) m_live = in_data;
      if (wr_en) case (addr)
        5'h00: m_en = wdata;
        5'h08: m_t0 = wdata;
        5'h0C: m_t1 = wdata;
        5'h10: m_t2 = wdata;
        default: ;
      endcase
      m_sts = nxt;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [3:0] pp;
      for (int p = 0; p < 4; p++) pp[p] = |(m_sts[p*8 +: 8] & m_en[p*8 +: 8]);
      check("R10 irq", {31'd0, irq}, {31'd0, |(m_sts & m_en)});
      check("R10 port_pend", {28'd0, port_pend}, {28'd0, pp});
      check("R2 rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(logic [31:0] d);
    @(negedge clk); in_data = d; in_valid = 1;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk); addr = a; wr_en = 0; #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(5'h00, 32'h0, "R1 enable");
    rd(5'h04, 32'h0, "R1 status");
    rd(5'h08, 32'hFFFF_FFFF, "R1 type0");
    rd(5'h0C, 32'hFFFF_FFFF, "R1 type1");
    rd(5'h10, 32'h0, "R1 type2");
    rd(5'h14, 32'h0, "R1 live");
    check("R1 irq", {31'd0, irq}, 32'd0);
    // lines 0..7: rise, fall100, both, high, low, none, fall101, fall111; line 8 rise
    wr(5'h08, 32'h0000_01C9);
    wr(5'h0C, 32'h0000_009C);
    wr(5'h10, 32'h0000_00D2);
    rd(5'h08, 32'h0000_01C9, "R2 type0 write");
    wr(5'h14, 32'h1234_5678);
    rd(5'h14, 32'h0, "R2 live read-only");
    strobe(32'h0);
    rd(5'h04, 32'h0000_0010, "R8 level low on zero sample");
    wr(5'h04, 32'h0000_0010);
    rd(5'h04, 32'h0, "R3 clear");
    strobe(32'h0000_00FF);
    rd(5'h04, 32'h0000_000D, "R4 R6 R7 rising/both/high");
    wr(5'h04, 32'h0);
    rd(5'h04, 32'h0000_000D, "R3 zero write keeps");
    rd(5'h14, 32'h0000_00FF, "R12 live word");
    wr(5'h04, 32'hFFFF_FFFF);
    strobe(32'h0000_00FF);
    rd(5'h04, 32'h0000_0008, "R7 level high repeats");
    wr(5'h04, 32'hFFFF_FFFF);
    @(negedge clk); in_data = 32'h0;
    repeat (2) @(negedge clk);
    rd(5'h04, 32'h0, "R12 no strobe no event");
    strobe(32'h0);
    rd(5'h04, 32'h0000_00D6, "R5 R9 falling codes, none silent");
    check("R10 irq while disabled", {31'd0, irq}, 32'd0);
    wr(5'h00, 32'h0000_0004);
    #1 check("R10 irq enabled", {31'd0, irq}, 32'd1);
    check("R10 pending port0", {28'd0, port_pend}, 32'd1);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0000_0100);
    strobe(32'h0000_0100);
    rd(5'h04, 32'h0000_0110, "R10 port1 status");
    check("R10 pending port1", {28'd0, port_pend}, 32'd2);
    @(negedge clk); addr = 5'h04; wdata = 32'h0000_0010; wr_en = 1;
    in_data = 32'h0000_0100; in_valid = 1;
    @(negedge clk); wr_en = 0; in_valid = 0;
    rd(5'h04, 32'h0000_0110, "R11 event beats clear");
    wr(5'h04, 32'h0000_0010);
    rd(5'h04, 32'h0000_0100, "R11 later clear");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule